// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A control byte chooses the frame shape: five to eight data bits, an optional parity bit of odd or even sense, and a stop interval of one, one and a half or two bit times. The stop interval depends on both the stop-select bit and the word length.

Timing comes from an external strobe running at sixteen times the bit rate. The block counts these strobes and never divides the clock itself. A character is handed over with a valid/ready handshake. The control byte is captured together with the character, so the format of a frame cannot change while that frame is on the line. A flag reports when the shift register has drained and the line is back at idle.

Top module: `fmtuart_tx`

## Requirements
- R1: After reset the serial line is high, `tx_ready` is 1 and `tx_empty` is 1.
- R2: `ctrl[1:0]` sets the word length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. The frame is a low start bit, then the data bits least-significant first. Every bit lasts exactly 16 `baud_tick` strobes, and the line changes only after a strobe or an accept.
- R3: With `ctrl[3]` = 0 no parity bit is sent, and the stop interval follows the last data bit directly.
- R4: With `ctrl[3]` = 1 a parity bit follows the last data bit. `ctrl[4]` = 0 makes the number of ones across the data bits and the parity bit odd. `ctrl[4]` = 1 makes that number even.
- R5: With `ctrl[2]` = 0 the stop interval is high for 16 strobes, for every word length.
- R6: With `ctrl[2]` = 1 and a 5-bit word the stop interval is high for 24 strobes.
- R7: With `ctrl[2]` = 1 and a 6-, 7- or 8-bit word the stop interval is high for 32 strobes.
- R8: `tx_ready` is 1 only while the transmitter is idle. A character is taken at the clock edge where `tx_valid` and `tx_ready` are both 1. While a frame is in progress, `tx_valid` has no effect on the frame.
- R9: The control byte is captured when a character is accepted. A change to `ctrl` during a frame does not alter that frame.
- R10: `tx_empty` falls when a character is accepted. It rises, together with `tx_ready`, in the cycle after the final stop strobe.
- R11: Bits of `tx_data` above the selected word length are neither sent nor counted in the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| ctrl | input | 8 | Frame format control byte; bits 7:5 unused |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter idle, character will be taken |
| tx_line | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Shift register drained, line idle |

## Verification
Directed frames step through all four word lengths, with parity off, odd and even, and with both stop settings. This isolates the 24-strobe stop case from the 32-strobe case and separates the two parity senses. Random frames then use random control bytes, data with random upper bits, and strobes that arrive on a random subset of cycles. The upper bits show whether data above the word length leaks into the frame or the parity. The irregular strobes show whether bit timing counts strobes rather than clocks. Some random frames also change `ctrl` and raise `tx_valid` in mid-frame. This tells a design that captures the format and the character at acceptance from one that follows the live inputs.

// File: rtl/fmtuart_pkg.sv
package fmtuart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       par_even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] len_sel;
    } line_fmt_t;

    function automatic line_fmt_t unpack_ctrl(input logic [4:0] c);
        line_fmt_t f;
        f.len_sel   = c[1:0];
        f.stop_long = c[2];
        f.par_en    = c[3];
        f.par_even  = c[4];
        return f;
    endfunction

endpackage

// File: rtl/fmtuart_fmt_decode.sv
module fmtuart_fmt_decode
    import fmtuart_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int MIN_WORD   = 5,
    parameter int OVERSAMPLE = 16,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 6
) (
    input  line_fmt_t          fmt,
    output logic [IDX_W-1:0]   last_idx,
    output logic [CNT_W-1:0]   stop_ticks,
    output logic [CHAR_W-1:0]  data_mask
);
    localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVERSAMPLE);

    always_comb begin
        last_idx = IDX_W'(MIN_WORD - 1) + IDX_W'(fmt.len_sel);
    end

    always_comb begin
        if (!fmt.stop_long) begin
            stop_ticks = STOP_ONE;
        end else if (fmt.len_sel == 2'b00) begin
            stop_ticks = STOP_HALF;
        end else begin
            stop_ticks = STOP_TWO;
        end
    end

    for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
        assign data_mask[i] = (IDX_W'(i) <= last_idx);
    end

endmodule

// File: rtl/fmtuart_parity.sv
module fmtuart_parity #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] data,
    input  logic [CHAR_W-1:0] mask,
    input  logic              even,
    output logic              par_bit
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^(data & mask);
        // even sense: bit equals the data parity; odd sense: its complement
        par_bit  = even ? ones_odd : ~ones_odd;
    end

endmodule

// File: rtl/fmtuart_bit_timer.sv
module fmtuart_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = tick && !hold && (cnt_q == limit - CNT_W'(1));
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = '0;
        end else if (done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fmtuart_tx.sv
module fmtuart_tx
    import fmtuart_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int CTRL_W     = 8,
    parameter int MIN_WORD   = 5,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    output logic              tx_empty
);
    localparam int IDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
    localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(OVERSAMPLE);

    typedef struct packed {
        tx_state_e         st;
        logic [CHAR_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic              par_en;
        logic              par_bit;
        logic [CNT_W-1:0]  stop_lim;
        logic              empty;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    line_fmt_t         fmt_in;
    logic [IDX_W-1:0]  dec_last;
    logic [CNT_W-1:0]  dec_stop;
    logic [CHAR_W-1:0] dec_mask;
    logic              dec_par;
    logic              timer_hold;
    logic              bit_done;
    logic [CNT_W-1:0]  timer_limit;
    logic              unused_ctrl_hi;

    assign fmt_in         = unpack_ctrl(ctrl[4:0]);
    assign unused_ctrl_hi = ^ctrl[CTRL_W-1:5];

    fmtuart_fmt_decode #(
        .CHAR_W     (CHAR_W),
        .MIN_WORD   (MIN_WORD),
        .OVERSAMPLE (OVERSAMPLE),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_decode (
        .fmt        (fmt_in),
        .last_idx   (dec_last),
        .stop_ticks (dec_stop),
        .data_mask  (dec_mask)
    );

    fmtuart_parity #(
        .CHAR_W (CHAR_W)
    ) u_parity (
        .data    (tx_data),
        .mask    (dec_mask),
        .even    (fmt_in.par_even),
        .par_bit (dec_par)
    );

    assign timer_hold  = (r_q.st == ST_IDLE);
    assign timer_limit = (r_q.st == ST_STOP) ? r_q.stop_lim : BIT_TICKS;

    fmtuart_bit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (timer_hold),
        .tick  (baud_tick),
        .limit (timer_limit),
        .done  (bit_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tx_valid) begin
                    r_d.st       = ST_START;
                    r_d.shreg    = tx_data;
                    r_d.idx      = '0;
                    r_d.last     = dec_last;
                    r_d.par_en   = fmt_in.par_en;
                    r_d.par_bit  = dec_par;
                    r_d.stop_lim = dec_stop;
                    r_d.empty    = 1'b0;
                end
            end
            ST_START: begin
                if (bit_done) begin
                    r_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_done) begin
                    r_d.shreg = r_q.shreg >> 1;
                    if (r_q.idx == r_q.last) begin
                        r_d.st = r_q.par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (bit_done) begin
                    r_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    r_d.st    = ST_IDLE;
                    r_d.empty = 1'b1;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.empty = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.shreg    <= '0;
            r_q.idx      <= '0;
            r_q.last     <= '0;
            r_q.par_en   <= 1'b0;
            r_q.par_bit  <= 1'b0;
            r_q.stop_lim <= BIT_TICKS;
            r_q.empty    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = r_q.shreg[0];
            ST_PARITY: tx_line = r_q.par_bit;
            default:   tx_line = 1'b1;
        endcase
    end

    assign tx_ready = (r_q.st == ST_IDLE);
    assign tx_empty = r_q.empty;

endmodule

// File: rtl/fmtuart_tx_chk.sv
module fmtuart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_line,
    input logic tx_empty
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_line);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !tx_empty));

    // R8
    ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(tx_valid));

    // R10
    empty_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(baud_tick) && tx_ready));

    // R2
    line_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(baud_tick) && !$past(tx_valid && tx_ready)) |-> $stable(tx_line));

endmodule

bind fmtuart_tx fmtuart_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_line   (tx_line),
    .tx_empty  (tx_empty)
);

// File: tb/fmtuart_tx_tb.sv
module fmtuart_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       tx_line;
    logic       tx_empty;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic samp [0:255];

    always #10 clk = ~clk;

    fmtuart_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .ctrl      (ctrl),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_line   (tx_line),
        .tx_empty  (tx_empty)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int stop_of(input logic [7:0] c);
        if (!c[2]) return 16;
        if (c[1:0] == 2'b00) return 24;
        return 32;
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
        int ones = 0;
        for (int i = 0; i < nbits_of(c); i++) ones += int'(d[i]);
        // odd sense when c[4]=0: data ones plus parity bit must be odd
        return c[4] ? logic'(ones % 2) : logic'((ones % 2) == 0);
    endfunction

    function automatic int total_of(input logic [7:0] c);
        return 16 * (1 + nbits_of(c) + int'(c[3])) + stop_of(c);
    endfunction

    function automatic logic exp_line(input logic [7:0] d, input logic [7:0] c, input int k);
        int pos = k / 16;
        int n   = nbits_of(c);
        if (pos == 0) return 1'b0;
        if (pos <= n) return d[pos-1];
        if (c[3] && pos == n + 1) return par_of(d, c);
        return 1'b1;
    endfunction

    task automatic send(input logic [7:0] d, input logic [7:0] c,
                        input bit chg, input logic [7:0] c2, input bit poke);
        int total = total_of(c);
        int cnt = 0;
        int bad = 0;
        int first_bad = -1;
        int busy_err = 0;
        string tag;
        @(posedge clk); #1;
        tx_data = d; ctrl = c; tx_valid = 1'b1; baud_tick = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R8 ready before accept", int'(tx_ready), 1);
        @(posedge clk); #1;
        tx_valid = 1'b0;
        if (chg) ctrl = c2;
        forever begin
            baud_tick = logic'($urandom_range(0, 1));
            if (poke) begin
                tx_valid = (cnt < total / 2);
                tx_data  = ~d;
            end
            @(negedge clk);
            if (tx_ready || tx_empty) busy_err++;
            if (baud_tick) begin
                samp[cnt] = tx_line;
                cnt++;
            end
            if (cnt == total) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        baud_tick = 1'b0; tx_valid = 1'b0;
        @(negedge clk);
        for (int k = 0; k < total; k++) begin
            if (samp[k] !== exp_line(d, c, k)) begin
                if (first_bad < 0) first_bad = k;
                bad++;
            end
        end
        tag = chg ? "R9 frame bits after mid-frame ctrl change" :
              (poke ? "R8 frame bits with valid held while busy" :
                      "R2/R3/R4/R11 frame bits");
        check(bad == 0, tag, first_bad, -1);
        tag = !c[2] ? "R5 stop length 16" :
              (c[1:0] == 2'b00 ? "R6 stop length 24" : "R7 stop length 32");
        check(tx_ready == 1'b1 && tx_line == 1'b1, tag, int'(tx_ready), 1);
        check(tx_empty == 1'b1, "R10 empty after final stop tick", int'(tx_empty), 1);
        check(busy_err == 0, "R8/R10 ready and empty low during frame", busy_err, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_line == 1'b1, "R1 line after reset", int'(tx_line), 1);
        check(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);
        check(tx_empty == 1'b1, "R1 empty after reset", int'(tx_empty), 1);

        // directed: every length with parity off/odd/even and both stop settings
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    logic [7:0] c;
                    c = {3'b000, (pm == 2) ? 1'b1 : 1'b0, (pm != 0) ? 1'b1 : 1'b0,
                         logic'(sl), 2'(len)};
                    send(8'hA5 ^ 8'(len * 37 + pm), c, 1'b0, 8'h00, 1'b0);
                end
            end
        end
        // R11 upper bits set with a 5-bit word, odd parity: only 0x15 counts
        send(8'hF5, 8'h08, 1'b0, 8'h00, 1'b0);
        // R4 all-zero data, odd parity sends a 1; even sends a 0
        send(8'h00, 8'h0B, 1'b0, 8'h00, 1'b0);
        send(8'h00, 8'h1B, 1'b0, 8'h00, 1'b0);

        // random frames
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            logic [7:0] c;
            logic [7:0] c2;
            d  = 8'($urandom);
            c  = 8'($urandom);
            c2 = 8'($urandom);
            send(d, c, ($urandom_range(0, 2) == 0), c2, ($urandom_range(0, 2) == 0));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule